// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block sits beside a small 8-bit CPU core and widens its 16-bit logical addresses into 22-bit physical addresses covering 4 Mbytes. Code addresses are prefixed with a 6-bit segment number. Each segment is 64 Kbytes. Which segment register supplies that number depends on the requestor context: main-line fetch, interrupt-routine fetch or DMA. Data addresses go through one of four page registers. The top two logical bits pick the register, and its 8-bit value replaces those bits, which gives 16-Kbyte pages.

The block holds the code, interrupt and DMA segment registers, the four page registers and a mode register with two control bits. The first bit, save-segment, chooses how interrupts fetch code. When it is clear, the interrupt segment replaces the code segment for the whole service routine. When it is set, the interrupt segment is copied into the code segment at interrupt entry, and fetches then follow the code segment. The second bit, page-swap, moves the page registers from a paged window of the register file into an unpaged window normally occupied by port data registers. Software can then reach them without changing the register page pointer. Far jumps, calls and returns reload the code segment through a dedicated load strobe.

Top module: `seg_xlat_unit`

## Requirements
- R1: After reset all segment, page and mode state is zero, so every physical address equals its logical address with zero upper bits, and data bits [15:14] are cleared.
- R2: Outside interrupts (irq_active_i = 0), fetch_paddr_o = {code segment, fetch_addr_i}.
- R3: With save-segment clear and irq_active_i = 1, fetch_paddr_o = {interrupt segment, fetch_addr_i}.
- R4: With save-segment set, an irq_entry_i pulse copies the interrupt segment into the code segment at the next edge, and fetches then use the code segment even while irq_active_i = 1.
- R5: vec_seg_o always shows the interrupt segment, whatever the mode.
- R6: data_paddr_o = {page register selected by data_addr_i[15:14], data_addr_i[13:0]}, with independent page registers 0..3.
- R7: dma_paddr_o uses the interrupt segment when dma_alt_i = 0 and the DMA segment when dma_alt_i = 1.
- R8: With page-swap clear, page register k is written at address 0xF0+k on register page 21. Writes to 0xE0+k are ignored.
- R9: With page-swap set, page register k is written at 0xE0+k on any register page. Writes to 0xF0+k on page 21 are ignored.
- R10: far_ld_i loads far_seg_i into the code segment. In the same cycle, an irq_entry_i with save-segment set takes priority over it, and it takes priority over a register write to the code segment.
- R11: On register page 21, the code, interrupt and DMA segment registers sit at 0xF8, 0xF9 and 0xFA, and the mode register sits at 0xF6. In the mode register, bit 6 is save-segment and bit 5 is page-swap. Segment writes keep only data bits [5:0]. Writes on any other page to these addresses are ignored.
- R12: A register write changes the translated outputs only after the next rising clock edge. The outputs are combinational from the stored state and the context inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rf_we_i | input | 1 | Register-file write strobe |
| rf_page_i | input | 6 | Current register page |
| rf_addr_i | input | 8 | Register-file address |
| rf_wdata_i | input | 8 | Register write data |
| irq_entry_i | input | 1 | Interrupt entry pulse |
| irq_active_i | input | 1 | Service routine in progress |
| far_ld_i | input | 1 | Far jump/call/return segment load |
| far_seg_i | input | 6 | Segment for far load |
| fetch_addr_i | input | 16 | Logical code fetch address |
| data_addr_i | input | 16 | Logical data address |
| dma_addr_i | input | 16 | Logical DMA address |
| dma_alt_i | input | 1 | DMA uses its own segment when 1 |
| fetch_paddr_o | output | 22 | Physical code fetch address |
| data_paddr_o | output | 22 | Physical data address |
| dma_paddr_o | output | 22 | Physical DMA address |
| vec_seg_o | output | 6 | Segment of the interrupt vector table |

## Verification
The bench builds the block with its default parameters: 16-bit logical addresses, 6-bit segments, four pages and register page 21. These values make the full 22-bit address reachable, so the all-ones segment and the page values written through both windows are visible at the outputs. Segment writes of 0xFF are included to show that the upper data bits are dropped. Same-cycle collisions of interrupt entry, far load and register write are driven in both modes to expose the priority order.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;
  localparam logic [7:0] PAGE_WIN_A = 8'hF0;  // paged window, page regs when not swapped
  localparam logic [7:0] PORT_WIN_A = 8'hE0;  // unpaged window, page regs when swapped
  localparam logic [7:0] MODE_A     = 8'hF6;
  localparam logic [7:0] CODE_SEG_A = 8'hF8;
  localparam logic [7:0] IRQ_SEG_A  = 8'hF9;
  localparam logic [7:0] DMA_SEG_A  = 8'hFA;
  localparam int SWAP_BIT = 5;
  localparam int SAVE_BIT = 6;

  typedef struct packed {
    logic seg_save;
    logic page_swap;
  } mode_t;

  typedef enum logic [1:0] {
    SRC_CODE,
    SRC_IRQ,
    SRC_DMA
  } seg_src_e;
endpackage

// File: rtl/segxlat_regs.sv
module segxlat_regs
  import segxlat_pkg::*;
#(
  parameter int SEG_W     = 6,
  parameter int NUM_PAGES = 4,
  parameter int PG_W      = 8,
  parameter int REG_W     = 8,
  parameter int RPAGE_W   = 6,
  parameter int MAP_PAGE  = 21
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rf_we_i,
  input  logic [RPAGE_W-1:0]             rf_page_i,
  input  logic [7:0]                     rf_addr_i,
  input  logic [REG_W-1:0]               rf_wdata_i,
  input  logic                           irq_entry_i,
  input  logic                           far_ld_i,
  input  logic [SEG_W-1:0]               far_seg_i,
  output logic [SEG_W-1:0]               code_seg_o,
  output logic [SEG_W-1:0]               irq_seg_o,
  output logic [SEG_W-1:0]               dma_seg_o,
  output logic [NUM_PAGES-1:0][PG_W-1:0] page_o,
  output mode_t                          mode_o
);
  logic map_hit;
  assign map_hit = rf_we_i && (rf_page_i == RPAGE_W'(MAP_PAGE));

  logic [SEG_W-1:0] code_q, irq_q, dma_q;
  mode_t            mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      irq_q  <= '0;
      dma_q  <= '0;
      mode_q <= '0;
    end else begin
      if (irq_entry_i && mode_q.seg_save)                code_q <= irq_q;
      else if (far_ld_i)                                 code_q <= far_seg_i;
      else if (map_hit && rf_addr_i == CODE_SEG_A)       code_q <= rf_wdata_i[SEG_W-1:0];
      if (map_hit && rf_addr_i == IRQ_SEG_A)             irq_q  <= rf_wdata_i[SEG_W-1:0];
      if (map_hit && rf_addr_i == DMA_SEG_A)             dma_q  <= rf_wdata_i[SEG_W-1:0];
      if (map_hit && rf_addr_i == MODE_A) begin
        mode_q.seg_save  <= rf_wdata_i[SAVE_BIT];
        mode_q.page_swap <= rf_wdata_i[SWAP_BIT];
      end
    end
  end

  for (genvar k = 0; k < NUM_PAGES; k++) begin : g_page
    logic hit_paged, hit_unpaged, wr;
    logic [PG_W-1:0] pg_q;
    assign hit_paged   = map_hit && (rf_addr_i == PAGE_WIN_A + 8'(k));
    assign hit_unpaged = rf_we_i && (rf_addr_i == PORT_WIN_A + 8'(k));
    assign wr          = mode_q.page_swap ? hit_unpaged : hit_paged;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  pg_q <= '0;
      else if (wr)  pg_q <= rf_wdata_i[PG_W-1:0];
    end
    assign page_o[k] = pg_q;
  end

  assign code_seg_o = code_q;
  assign irq_seg_o  = irq_q;
  assign dma_seg_o  = dma_q;
  assign mode_o     = mode_q;
endmodule

// File: rtl/segxlat_code.sv
module segxlat_code
  import segxlat_pkg::*;
#(
  parameter int SEG_W = 6,
  parameter int LOG_W = 16
) (
  input  logic [SEG_W-1:0]       code_seg_i,
  input  logic [SEG_W-1:0]       irq_seg_i,
  input  logic [SEG_W-1:0]       dma_seg_i,
  input  mode_t                  mode_i,
  input  logic                   irq_active_i,
  input  logic                   dma_alt_i,
  input  logic [LOG_W-1:0]       fetch_addr_i,
  input  logic [LOG_W-1:0]       dma_addr_i,
  output logic [SEG_W+LOG_W-1:0] fetch_paddr_o,
  output logic [SEG_W+LOG_W-1:0] dma_paddr_o,
  output logic [SEG_W-1:0]       vec_seg_o
);
  seg_src_e fetch_src, dma_src;

  always_comb begin
    fetch_src = (irq_active_i && !mode_i.seg_save) ? SRC_IRQ : SRC_CODE;
    dma_src   = dma_alt_i ? SRC_DMA : SRC_IRQ;
  end

  function automatic logic [SEG_W-1:0] pick(seg_src_e s, logic [SEG_W-1:0] c,
                                            logic [SEG_W-1:0] i, logic [SEG_W-1:0] d);
    case (s)
      SRC_IRQ: pick = i;
      SRC_DMA: pick = d;
      default: pick = c;
    endcase
  endfunction

  assign fetch_paddr_o = {pick(fetch_src, code_seg_i, irq_seg_i, dma_seg_i), fetch_addr_i};
  assign dma_paddr_o   = {pick(dma_src, code_seg_i, irq_seg_i, dma_seg_i), dma_addr_i};
  assign vec_seg_o     = irq_seg_i;
endmodule

// File: rtl/segxlat_data.sv
module segxlat_data #(
  parameter int LOG_W     = 16,
  parameter int NUM_PAGES = 4,
  parameter int PG_W      = 8,
  parameter int SEL_W     = $clog2(NUM_PAGES),
  parameter int OFS_W     = LOG_W - SEL_W
) (
  input  logic [NUM_PAGES-1:0][PG_W-1:0] page_i,
  input  logic [LOG_W-1:0]               data_addr_i,
  output logic [PG_W+OFS_W-1:0]          data_paddr_o
);
  logic [SEL_W-1:0] sel;
  assign sel          = data_addr_i[LOG_W-1 -: SEL_W];
  assign data_paddr_o = {page_i[sel], data_addr_i[OFS_W-1:0]};
endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
  import segxlat_pkg::*;
#(
  parameter int LOG_W     = 16,
  parameter int SEG_W     = 6,
  parameter int NUM_PAGES = 4,
  parameter int REG_W     = 8,
  parameter int RPAGE_W   = 6,
  parameter int MAP_PAGE  = 21,
  localparam int PHYS_W   = LOG_W + SEG_W,
  localparam int SEL_W    = $clog2(NUM_PAGES),
  localparam int OFS_W    = LOG_W - SEL_W,
  localparam int PG_W     = PHYS_W - OFS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rf_we_i,
  input  logic [RPAGE_W-1:0] rf_page_i,
  input  logic [7:0]         rf_addr_i,
  input  logic [REG_W-1:0]   rf_wdata_i,
  input  logic               irq_entry_i,
  input  logic               irq_active_i,
  input  logic               far_ld_i,
  input  logic [SEG_W-1:0]   far_seg_i,
  input  logic [LOG_W-1:0]   fetch_addr_i,
  input  logic [LOG_W-1:0]   data_addr_i,
  input  logic [LOG_W-1:0]   dma_addr_i,
  input  logic               dma_alt_i,
  output logic [PHYS_W-1:0]  fetch_paddr_o,
  output logic [PHYS_W-1:0]  data_paddr_o,
  output logic [PHYS_W-1:0]  dma_paddr_o,
  output logic [SEG_W-1:0]   vec_seg_o
);
  logic [SEG_W-1:0]               code_seg_q, irq_seg_q, dma_seg_q;
  logic [NUM_PAGES-1:0][PG_W-1:0] page_q;
  mode_t                          mode_q;

  segxlat_regs #(
    .SEG_W(SEG_W), .NUM_PAGES(NUM_PAGES), .PG_W(PG_W),
    .REG_W(REG_W), .RPAGE_W(RPAGE_W), .MAP_PAGE(MAP_PAGE)
  ) i_regs (
    .clk_i, .rst_ni, .rf_we_i, .rf_page_i, .rf_addr_i, .rf_wdata_i,
    .irq_entry_i, .far_ld_i, .far_seg_i,
    .code_seg_o(code_seg_q), .irq_seg_o(irq_seg_q), .dma_seg_o(dma_seg_q),
    .page_o(page_q), .mode_o(mode_q)
  );

  segxlat_code #(.SEG_W(SEG_W), .LOG_W(LOG_W)) i_code (
    .code_seg_i(code_seg_q), .irq_seg_i(irq_seg_q), .dma_seg_i(dma_seg_q),
    .mode_i(mode_q), .irq_active_i, .dma_alt_i, .fetch_addr_i, .dma_addr_i,
    .fetch_paddr_o, .dma_paddr_o, .vec_seg_o
  );

  segxlat_data #(.LOG_W(LOG_W), .NUM_PAGES(NUM_PAGES), .PG_W(PG_W)) i_data (
    .page_i(page_q), .data_addr_i, .data_paddr_o
  );
endmodule

// File: rtl/segxlat_chk.sv
module segxlat_chk
  import segxlat_pkg::*;
#(
  parameter int SEG_W  = 6,
  parameter int LOG_W  = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   rf_we_i,
  input logic                   irq_entry_i,
  input logic                   irq_active_i,
  input logic                   far_ld_i,
  input logic [SEG_W-1:0]       far_seg_i,
  input logic                   dma_alt_i,
  input logic [SEG_W-1:0]       code_seg_q,
  input logic [SEG_W-1:0]       irq_seg_q,
  input logic [SEG_W-1:0]       dma_seg_q,
  input mode_t                  mode_q,
  input logic [SEG_W+LOG_W-1:0] fetch_paddr_o,
  input logic [SEG_W+LOG_W-1:0] dma_paddr_o
);
  // R4
  irq_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_entry_i && mode_q.seg_save) |=> code_seg_q == $past(irq_seg_q));
  // R10
  far_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (far_ld_i && !(irq_entry_i && mode_q.seg_save)) |=> code_seg_q == $past(far_seg_i));
  // R12
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rf_we_i && !far_ld_i && !irq_entry_i) |=> $stable(code_seg_q));
  // R3
  irq_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_active_i && !mode_q.seg_save) |-> fetch_paddr_o[SEG_W+LOG_W-1:LOG_W] == irq_seg_q);
  // R7
  dma_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_alt_i |-> dma_paddr_o[SEG_W+LOG_W-1:LOG_W] == dma_seg_q);
endmodule

bind seg_xlat_unit segxlat_chk #(.SEG_W(SEG_W), .LOG_W(LOG_W)) i_chk (
  .clk_i, .rst_ni, .rf_we_i, .irq_entry_i, .irq_active_i, .far_ld_i, .far_seg_i,
  .dma_alt_i, .code_seg_q, .irq_seg_q, .dma_seg_q, .mode_q, .fetch_paddr_o, .dma_paddr_o
);

// File: tb/test_seg_xlat_unit.sv
`timescale 1ns/1ps
module test_seg_xlat_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rf_we_i = 1'b0;
  logic [5:0]  rf_page_i = '0;
  logic [7:0]  rf_addr_i = '0;
  logic [7:0]  rf_wdata_i = '0;
  logic        irq_entry_i = 1'b0;
  logic        irq_active_i = 1'b0;
  logic        far_ld_i = 1'b0;
  logic [5:0]  far_seg_i = '0;
  logic [15:0] fetch_addr_i = '0;
  logic [15:0] data_addr_i = '0;
  logic [15:0] dma_addr_i = '0;
  logic        dma_alt_i = 1'b0;
  logic [21:0] fetch_paddr_o, data_paddr_o, dma_paddr_o;
  logic [5:0]  vec_seg_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  seg_xlat_unit i_seg_xlat_unit (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk_i); #1;
  endtask

  task automatic wr(logic [5:0] pg, logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    rf_we_i = 1'b1; rf_page_i = pg; rf_addr_i = a; rf_wdata_i = d;
    @(negedge clk_i);
    rf_we_i = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    fetch_addr_i = 16'h1234; data_addr_i = 16'hC123; dma_addr_i = 16'hBEEF;
    #1;
    check("R1 fetch", fetch_paddr_o, 32'h001234);
    check("R1 data", data_paddr_o, 32'h000123);
    check("R1 dma", dma_paddr_o, 32'h00BEEF);
    check("R1 vec", vec_seg_o, 32'h0);
  endtask

  task automatic t_timing();
    @(negedge clk_i);
    rf_we_i = 1'b1; rf_page_i = 6'd21; rf_addr_i = 8'hF8; rf_wdata_i = 8'h2A;
    #1;
    check("R12 before edge", fetch_paddr_o, 32'h001234);
    @(posedge clk_i); #1;
    check("R12 after edge", fetch_paddr_o, {10'h0, 6'h2A, 16'h1234});
    @(negedge clk_i); rf_we_i = 1'b0;
  endtask

  task automatic t_normal();
    fetch_addr_i = 16'hFFFF;
    settle();
    check("R2 fetch", fetch_paddr_o, {10'h0, 6'h2A, 16'hFFFF});
    wr(6'd21, 8'hF8, 8'hFF);
    check("R11 seg trunc", fetch_paddr_o, 32'h3FFFFF);
    wr(6'd20, 8'hF8, 8'h05);
    check("R11 wrong page", fetch_paddr_o, 32'h3FFFFF);
  endtask

  task automatic t_irq_shared();
    wr(6'd21, 8'hF9, 8'h15);
    irq_active_i = 1'b1; fetch_addr_i = 16'h0040;
    #1;
    check("R3 irq fetch", fetch_paddr_o, {10'h0, 6'h15, 16'h0040});
    check("R5 vec", vec_seg_o, 32'h15);
    // entry without save-segment: code seg unchanged
    @(negedge clk_i); irq_entry_i = 1'b1; @(negedge clk_i); irq_entry_i = 1'b0;
    irq_active_i = 1'b0; #1;
    check("R4 no seed when clear", fetch_paddr_o, {10'h0, 6'h3F, 16'h0040});
  endtask

  task automatic t_irq_save();
    wr(6'd21, 8'hF6, 8'h40);
    irq_active_i = 1'b1; #1;
    check("R4 uses code seg", fetch_paddr_o, {10'h0, 6'h3F, 16'h0040});
    @(negedge clk_i); irq_entry_i = 1'b1; @(negedge clk_i); irq_entry_i = 1'b0; #1;
    check("R4 seeded", fetch_paddr_o, {10'h0, 6'h15, 16'h0040});
    @(negedge clk_i); far_ld_i = 1'b1; far_seg_i = 6'h07;
    @(negedge clk_i); far_ld_i = 1'b0; #1;
    check("R10 far load in irq", fetch_paddr_o, {10'h0, 6'h07, 16'h0040});
    check("R5 vec save mode", vec_seg_o, 32'h15);
    // entry and far load together: entry wins
    @(negedge clk_i); far_ld_i = 1'b1; far_seg_i = 6'h22; irq_entry_i = 1'b1;
    @(negedge clk_i); far_ld_i = 1'b0; irq_entry_i = 1'b0; #1;
    check("R10 entry beats far", fetch_paddr_o, {10'h0, 6'h15, 16'h0040});
    irq_active_i = 1'b0;
    wr(6'd21, 8'hF6, 8'h00);
    // far load vs register write, entry ignored in shared mode
    @(negedge clk_i);
    far_ld_i = 1'b1; far_seg_i = 6'h31; irq_entry_i = 1'b1;
    rf_we_i = 1'b1; rf_page_i = 6'd21; rf_addr_i = 8'hF8; rf_wdata_i = 8'h0C;
    @(negedge clk_i); far_ld_i = 1'b0; irq_entry_i = 1'b0; rf_we_i = 1'b0; #1;
    check("R10 far beats write", fetch_paddr_o, {10'h0, 6'h31, 16'h0040});
  endtask

  task automatic t_pages();
    for (int k = 0; k < 4; k++) wr(6'd21, 8'hF0 + 8'(k), 8'h11 * 8'(k + 1));
    for (int k = 0; k < 4; k++) begin
      data_addr_i = {2'(k), 14'h2A5}; #1;
      check("R6 page select", data_paddr_o, {10'h0, 8'h11 * 8'(k + 1), 14'h2A5});
    end
    wr(6'd3, 8'hE1, 8'hAB);
    data_addr_i = 16'h4001; #1;
    check("R8 port window ignored", data_paddr_o, {10'h0, 8'h22, 14'h0001});
    wr(6'd5, 8'hF2, 8'hCD);
    data_addr_i = 16'h8001; #1;
    check("R11 page reg wrong page", data_paddr_o, {10'h0, 8'h33, 14'h0001});
  endtask

  task automatic t_swap();
    wr(6'd21, 8'hF6, 8'h20);
    wr(6'd3, 8'hE3, 8'hF0);
    data_addr_i = 16'hFFFF; #1;
    check("R9 unpaged write", data_paddr_o, {10'h0, 8'hF0, 14'h3FFF});
    wr(6'd21, 8'hF0, 8'h99);
    data_addr_i = 16'h0000; #1;
    check("R9 paged ignored", data_paddr_o, {10'h0, 8'h11, 14'h0});
    check("R3 swap leaves fetch", fetch_paddr_o, {10'h0, 6'h31, 16'h0040});
  endtask

  task automatic t_dma();
    dma_addr_i = 16'h8421; dma_alt_i = 1'b0; #1;
    check("R7 irq seg", dma_paddr_o, {10'h0, 6'h15, 16'h8421});
    wr(6'd21, 8'hFA, 8'hF3);
    check("R7 alt clear still irq", dma_paddr_o, {10'h0, 6'h15, 16'h8421});
    dma_alt_i = 1'b1; #1;
    check("R7 own seg", dma_paddr_o, {10'h0, 6'h33, 16'h8421});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_timing();
    t_normal();
    t_irq_shared();
    t_irq_save();
    t_pages();
    t_swap();
    t_dma();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule